// File: doc/BRIEF.md
# Partition-Credit Dual-Clock Buffer

This block carries a stream of data words from a fast write clock domain into a slower read clock domain. It does not pass read and write pointers across the boundary on every word. Instead, the shared storage is divided into equal partitions, and only partition-level events cross between the clocks.

When the writer finishes filling a partition, it flips a single level. The read domain resynchronizes that level and turns each change into a one-cycle pulse, which adds one readable partition to a counter. In the other direction, when the reader has drained a partition, a matching event goes back to the writer and returns one partition of write space. Both sides walk the storage with their own circular address counters.

A writer that finds no free partition is refused, and the refusal shows on a stall output. Partitions must be deep enough for every completion event to be seen on the far side. With the toggle scheme used here, that means one partition must take longer to fill than one period of the read clock.

Top module: `pcb_buffer`

## Requirements
- R1: After reset, rd_valid is 0, wr_ready is 1 and wr_stall is 0. Both address counters point at word 0 of partition 0, and every partition is free.
- R2: Words leave on rd_data in exactly the order in which they were accepted, with none lost and none repeated. A word is accepted on a wr_clk edge where wr_en=1 and wr_ready=1. A word is consumed on a rd_clk edge where rd_en=1 and rd_valid=1.
- R3: rd_valid stays 0 while the partition being filled is incomplete. It becomes 1 within a few read cycles after the last word of that partition is accepted (the bench allows 6 read cycles).
- R4: Once all PARTS partitions are written and none is drained, wr_ready is 0 from the next write cycle. In that state a word offered with wr_en=1 is refused and is never delivered on the read side.
- R5: After the reader drains a partition, wr_ready returns to 1 within a few write cycles (the bench allows 8).
- R6: rd_en while rd_valid=0 has no effect: the read address does not advance.
- R7: rd_valid returns to 0 once every completed partition is drained, even if a partly filled partition remains.
- R8: wr_stall is 1 exactly when wr_en=1 and wr_ready=0. It is 0 whenever wr_en=0.
- R9: Both address counters wrap from the last word of storage back to word 0. Data stays correct over several laps of the storage, with read and write duty cycles varied independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Offer wr_data this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | The partition being filled is free, so a word can be accepted |
| wr_stall | output | 1 | An offered word is refused this cycle |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Consume the word on rd_data this cycle |
| rd_data | output | DATA_W | Word at the read address |
| rd_valid | output | 1 | At least one complete partition is readable |

## Verification
A directed pass first fills the buffer one word short of a partition, so the bench can tell partition-level release apart from word-level release. It then fills the buffer completely to exercise the refusal and stall path, drains one partition to watch write space come back, and drains the rest to see rd_valid drop. A sweep then streams several laps with four combinations of write gaps and read duty. Every word carries a value computed from its pattern and index, so any reordering, loss, duplication or wrap error shows as a miscompare. A final case leaves a half-filled partition, to show that incomplete data is never released.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    // Credit counters: wide enough for any partition count up to 255.
    typedef logic [7:0] credit_t;

    // One credit step: subtract on a local completion, add on a remote event.
    function automatic credit_t credit_next(credit_t c, logic dec, logic inc);
        credit_t r;
        r = c;
        if (dec && !inc) r = c - 8'd1;
        else if (inc && !dec) r = c + 8'd1;
        return r;
    endfunction

    // True when an address sits on the last word of its partition.
    function automatic logic seg_last(logic [31:0] addr, int unsigned seg_w);
        logic [31:0] mask;
        mask = (32'd1 << seg_w) - 32'd1;
        return (addr & mask) == mask;
    endfunction
endpackage

// File: rtl/pcb_event_sync.sv
module pcb_event_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic                 src_level;
    logic [SYNC_STAGES:0] dst_chain;

    // Each source event flips a level, so a slow receiver can still see it.
    always_ff @(posedge src_clk) begin
        if (src_rst)        src_level <= 1'b0;
        else if (src_pulse) src_level <= ~src_level;
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) dst_chain <= '0;
        else         dst_chain <= {dst_chain[SYNC_STAGES-1:0], src_level};
    end

    // Any change of the synchronized level becomes a one-cycle pulse.
    assign dst_pulse = dst_chain[SYNC_STAGES] ^ dst_chain[SYNC_STAGES-1];
endmodule

// File: rtl/pcb_wr_ctrl.sv
module pcb_wr_ctrl
    import pcb_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned SEG_W  = 2,
    parameter int unsigned PARTS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              freed,
    output logic              accept,
    output logic              seg_done,
    output logic              ready,
    output logic [ADDR_W-1:0] ptr,
    output credit_t           free_cnt
);
    assign ready    = free_cnt != 8'd0;
    assign accept   = push && ready;
    assign seg_done = accept && seg_last(32'(ptr), SEG_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            free_cnt <= credit_t'(PARTS);
        end else begin
            if (accept) ptr <= ptr + 1'b1;
            free_cnt <= credit_next(free_cnt, seg_done, freed);
        end
    end
endmodule

// File: rtl/pcb_rd_ctrl.sv
module pcb_rd_ctrl
    import pcb_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic              filled,
    output logic              valid,
    output logic              seg_done,
    output logic [ADDR_W-1:0] ptr,
    output credit_t           avail_cnt
);
    logic take;

    assign valid    = avail_cnt != 8'd0;
    assign take     = pop && valid;
    assign seg_done = take && seg_last(32'(ptr), SEG_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            avail_cnt <= 8'd0;
        end else begin
            if (take) ptr <= ptr + 1'b1;
            avail_cnt <= credit_next(avail_cnt, seg_done, filled);
        end
    end
endmodule

// File: rtl/pcb_mem.sv
module pcb_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Read words are stable: a partition is only read after its fill event arrives.
    assign rdata = cells[raddr];
endmodule

// File: rtl/pcb_buffer.sv
module pcb_buffer
    import pcb_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned PARTS       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              wr_stall,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int unsigned ADDR_W    = $clog2(DEPTH);
    localparam int unsigned SEG_DEPTH = DEPTH / PARTS;
    localparam int unsigned SEG_W     = $clog2(SEG_DEPTH);

    logic              wr_accept, wr_seg_done, freed_wr;
    logic              rd_seg_done, filled_rd;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    credit_t           free_cnt, avail_cnt;

    pcb_wr_ctrl #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PARTS(PARTS)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .push(wr_en), .freed(freed_wr),
        .accept(wr_accept), .seg_done(wr_seg_done), .ready(wr_ready),
        .ptr(wr_ptr), .free_cnt(free_cnt)
    );

    pcb_rd_ctrl #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .pop(rd_en), .filled(filled_rd),
        .valid(rd_valid), .seg_done(rd_seg_done), .ptr(rd_ptr),
        .avail_cnt(avail_cnt)
    );

    // Filled partitions travel write -> read.
    pcb_event_sync #(.SYNC_STAGES(SYNC_STAGES)) u_fill_x (
        .src_clk(wr_clk), .src_rst(wr_rst), .src_pulse(wr_seg_done),
        .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_pulse(filled_rd)
    );

    // Freed partitions travel read -> write.
    pcb_event_sync #(.SYNC_STAGES(SYNC_STAGES)) u_free_x (
        .src_clk(rd_clk), .src_rst(rd_rst), .src_pulse(rd_seg_done),
        .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_pulse(freed_wr)
    );

    pcb_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(wr_accept), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(rd_ptr), .rdata(rd_data)
    );

    assign wr_stall = wr_en && !wr_ready;
endmodule

// File: rtl/pcb_buffer_chk.sv
module pcb_buffer_chk
    import pcb_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned PARTS  = 4
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_en,
    input logic              wr_ready,
    input logic              wr_stall,
    input logic [ADDR_W-1:0] wr_ptr,
    input credit_t           free_cnt,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_ptr,
    input credit_t           avail_cnt,
    input logic              filled_rd
);
    a_r4_free_bound: assert property (@(posedge wr_clk) disable iff (wr_rst)
        free_cnt <= credit_t'(PARTS));

    a_r7_avail_bound: assert property (@(posedge rd_clk) disable iff (rd_rst)
        avail_cnt <= credit_t'(PARTS));

    a_r8_stall_blocked: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_stall |-> !wr_ready);

    a_r8_no_stall_idle: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !wr_en |-> !wr_stall);

    a_r4_hold_when_stalled: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_stall |=> wr_ptr == $past(wr_ptr));

    a_r6_idle_read: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_valid) |=> rd_ptr == $past(rd_ptr));

    a_r2_read_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_valid) |=> rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1));

    a_r3_fill_releases: assert property (@(posedge rd_clk) disable iff (rd_rst)
        filled_rd |=> rd_valid);
endmodule

bind pcb_buffer pcb_buffer_chk #(.ADDR_W(ADDR_W), .PARTS(PARTS)) u_chk (.*);

// File: tb/pcb_buffer_test.sv
module pcb_buffer_test;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned DEPTH  = 16;
    localparam int unsigned PARTS  = 4;
    localparam int unsigned SEG    = DEPTH / PARTS;

    logic              wr_clk = 1'b0, rd_clk = 1'b0;
    logic              wr_rst = 1'b1, rd_rst = 1'b1;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_ready, wr_stall, rd_valid;
    logic [DATA_W-1:0] rd_data;

    int vectors = 0;
    int miscompares = 0;
    int wd_cycles = 0;
    bit done = 1'b0;

    always #2.5 wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    pcb_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PARTS(PARTS)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_stall(wr_stall),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sweep_word(int p, int i);
        return {4'(p), 12'(i * 7 + 3)};
    endfunction

    task automatic wr_put(logic [15:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_take(string req, logic [15:0] exp);
        @(negedge rd_clk);
        check(req, 32'(rd_valid), 32'd1);
        check(req, 32'(rd_data), 32'(exp));
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge wr_clk) begin
        wd_cycles++;
        if (wd_cycles > 150000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd_cycles);
            finish_run();
        end
    end

    initial begin
        repeat (6) @(negedge rd_clk);
        wr_rst = 1'b0; rd_rst = 1'b0;
        @(negedge rd_clk);
        // R1: reset state
        check("R1 rd_valid", 32'(rd_valid), 0);
        check("R1 wr_ready", 32'(wr_ready), 1);
        check("R1/R8 wr_stall idle", 32'(wr_stall), 0);

        // R3: one word short of a partition is not released
        for (int k = 0; k < SEG - 1; k++) wr_put(16'hA000 + 16'(k));
        repeat (10) @(negedge rd_clk);
        check("R3 partial hidden", 32'(rd_valid), 0);
        // R6: reads while empty must not move the read address
        @(negedge rd_clk); rd_en = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en = 1'b0;
        wr_put(16'hA000 + 16'(SEG - 1));
        repeat (6) @(negedge rd_clk);
        check("R3 partition released", 32'(rd_valid), 1);
        check("R6 no advance while empty", 32'(rd_data), 32'hA000);

        // R4: fill every partition, then a further word is refused
        for (int k = SEG; k < DEPTH; k++) wr_put(16'hA000 + 16'(k));
        @(negedge wr_clk);
        check("R4 full not ready", 32'(wr_ready), 0);
        wr_en = 1'b1; wr_data = 16'hDEAD;
        #1;
        check("R8 stall when full", 32'(wr_stall), 1);
        @(negedge wr_clk);
        wr_en = 1'b0;
        #1;
        check("R8 stall drops with wr_en", 32'(wr_stall), 0);

        // R5: draining one partition returns write space
        for (int k = 0; k < SEG; k++) rd_take("R2 directed order", 16'hA000 + 16'(k));
        repeat (8) @(negedge wr_clk);
        check("R5 space returned", 32'(wr_ready), 1);

        // R7 and R4: drain the rest; refused word never appears
        for (int k = SEG; k < DEPTH; k++) rd_take("R2/R4 directed order", 16'hA000 + 16'(k));
        check("R7 empty after drain", 32'(rd_valid), 0);
        repeat (8) @(negedge rd_clk);
        check("R4 refused word absent", 32'(rd_valid), 0);

        // R9 and R2: multi-lap sweep with varied duty cycles
        for (int p = 0; p < 4; p++) begin
            fork
                begin : writer
                    int i = 0;
                    int cyc = 0;
                    while (i < 3 * DEPTH) begin
                        @(negedge wr_clk);
                        cyc++;
                        if (wr_ready && ((cyc % (p + 1)) != 1 || p == 0)) begin
                            wr_en = 1'b1; wr_data = sweep_word(p, i); i++;
                        end else begin
                            wr_en = 1'b0;
                        end
                    end
                    @(negedge wr_clk);
                    wr_en = 1'b0;
                end
                begin : reader
                    int got = 0;
                    int cyc = 0;
                    while (got < 3 * DEPTH) begin
                        @(negedge rd_clk);
                        cyc++;
                        rd_en = 1'b0;
                        if (rd_valid && (cyc % (4 - p)) == 0) begin
                            check("R9 lap data", 32'(rd_data), 32'(sweep_word(p, got)));
                            rd_en = 1'b1; got++;
                        end
                    end
                    @(negedge rd_clk);
                    rd_en = 1'b0;
                end
            join
            check("R7 empty after sweep", 32'(rd_valid), 0);
        end

        // R7: a half-filled partition stays unreadable
        wr_put(16'h5A00); wr_put(16'h5A01);
        repeat (10) @(negedge rd_clk);
        check("R7 partial not readable", 32'(rd_valid), 0);
        wr_put(16'h5A02); wr_put(16'h5A03);
        repeat (6) @(negedge rd_clk);
        for (int k = 0; k < SEG; k++) rd_take("R2 tail data", 16'h5A00 + 16'(k));
        check("R7 empty at end", 32'(rd_valid), 0);

        done = 1'b1;
        finish_run();
    end
endmodule